// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address for each beat of a four-beat burst in a synchronous memory front end. When a new access starts, it registers the whole base address. The two lowest bits of that address become the starting point of a two-bit wraparound sequence. After that, each asserted advance strobe moves the low bits to the next beat. The upper address bits stay fixed until the next load, so a burst never leaves its aligned four-word block.

Two beat orders are supported, and a static order-select input picks between them. In interleaved order, each beat's low bits are the starting low bits XORed with the beat number. In linear order, the low bits count upward modulo four from the start. When the advance strobe is not asserted, the current address is held, which suspends the burst. A new load at any point restarts the sequence from a new base. The block also reports the current beat number (0 to 3) so a neighbour can tell where the burst is.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset (`rstN` low) is active, and on the first sample after it is released, `curAddr` and `beatIdx` are both zero.
- R2: When `loadStb` is high at a rising clock edge, `curAddr` equals the `baseAddr` value sampled at that edge and `beatIdx` is 0 after that edge.
- R3: With `orderSel` = 1 (interleaved), `curAddr[1:0]` equals the starting low bits XOR `beatIdx`; for example, start 01 gives 01, 00, 11, 10.
- R4: With `orderSel` = 0 (linear), `curAddr[1:0]` equals (starting low bits + `beatIdx`) modulo 4; for example, start 10 gives 10, 11, 00, 01.
- R5: When `advanceN` is low and `loadStb` is low at a rising edge, `beatIdx` increases by one modulo 4.
- R6: When `advanceN` is high and `loadStb` is low at a rising edge, `curAddr` and `beatIdx` keep their values (burst suspend).
- R7: After the fourth beat, one more advance returns `curAddr` to the loaded base address. Advancing never changes `curAddr[ADDR_W-1:2]`.
- R8: A load restarts the burst from the new base even in the middle of a burst, and it wins over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadStb | input | 1 | Start of a new access; registers `baseAddr` |
| advanceN | input | 1 | Active-low request to step to the next beat |
| baseAddr | input | ADDR_W | Starting address of the access |
| orderSel | input | 1 | Beat order: 1 interleaved, 0 linear |
| curAddr | output | ADDR_W | Address of the current beat |
| beatIdx | output | 2 | Beat number within the burst, 0 to 3 |

## Verification
The properties assume that `orderSel` is static and changes only in a cycle where a load is also presented. The hold and step checks rely on this, because `curAddr` is formed combinationally from the order input. The stimulus follows the same rule: directed and random sequences choose a new order only together with a load, and keep it until the next one. Apart from that, load and advance are driven in every combination, including both at once, so the load-priority case is exercised repeatedly.

// File: rtl/burst_addr_gen_pkg.sv
package burst_addr_gen_pkg;
  localparam int BEAT_W = 2;

  typedef struct packed {
    logic capture;
    logic step;
  } bagStrobes_t;

  function automatic logic [BEAT_W-1:0] beatLow(input logic [BEAT_W-1:0] startLow,
                                                input logic [BEAT_W-1:0] beatNum,
                                                input logic interleaved);
    if (interleaved) return startLow ^ beatNum;
    return startLow + beatNum;
  endfunction
endpackage

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import burst_addr_gen_pkg::*;
(
  input  logic        loadStb,
  input  logic        advanceN,
  output bagStrobes_t stb
);
  always_comb begin
    stb.capture = loadStb;
    stb.step    = !loadStb && !advanceN;
  end
endmodule

// File: rtl/burst_addr_dp.sv
module burst_addr_dp
  import burst_addr_gen_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  bagStrobes_t       stb,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              orderSel,
  output logic [ADDR_W-1:0] curAddr,
  output logic [BEAT_W-1:0] beatIdx
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [BEAT_W-1:0] startLow;
  logic [BEAT_W-1:0] beatCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startLow <= '0;
      beatCnt  <= '0;
    end else if (stb.capture) begin
      startLow <= baseAddr[BEAT_W-1:0];
      beatCnt  <= '0;
    end else if (stb.step) begin
      beatCnt  <= beatCnt + 1'b1;
    end
  end

  generate
    if (UPPER_W > 0) begin : g_upper
      logic [UPPER_W-1:0] upperReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            upperReg <= '0;
        else if (stb.capture) upperReg <= baseAddr[ADDR_W-1:BEAT_W];
      end
      assign curAddr[ADDR_W-1:BEAT_W] = upperReg;
    end
  endgenerate

  assign curAddr[BEAT_W-1:0] = beatLow(startLow, beatCnt, orderSel);
  assign beatIdx = beatCnt;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_gen_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic              advanceN,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              orderSel,
  output logic [ADDR_W-1:0] curAddr,
  output logic [1:0]        beatIdx
);
  bagStrobes_t stb;

  burst_addr_ctrl u_ctrl (
    .loadStb  (loadStb),
    .advanceN (advanceN),
    .stb      (stb)
  );

  burst_addr_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .baseAddr (baseAddr),
    .orderSel (orderSel),
    .curAddr  (curAddr),
    .beatIdx  (beatIdx)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadStb,
  input logic              advanceN,
  input logic [ADDR_W-1:0] baseAddr,
  input logic              orderSel,
  input logic [ADDR_W-1:0] curAddr,
  input logic [1:0]        beatIdx
);
  // R1: reset state
  always_comb begin
    if (!rstN) begin
      a_reset_zero_r1: assert (curAddr == '0 && beatIdx == 2'd0);
    end
  end

  // R2 and R8: a load captures the base and restarts at beat 0, whatever advanceN is
  p_load_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> (curAddr == $past(baseAddr)) && (beatIdx == 2'd0));

  // R5: an advance without a load steps the beat count
  p_step_beat_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && !advanceN) |=> beatIdx == ($past(beatIdx) + 2'd1));

  // R6: suspend holds the address
  p_suspend_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && advanceN && $stable(orderSel)) |=>
      (orderSel != $past(orderSel)) || ($stable(curAddr) && $stable(beatIdx)));

  // R7: advancing never leaves the aligned four-word block
  p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!rstN)
    !loadStb |=> curAddr[ADDR_W-1:2] == $past(curAddr[ADDR_W-1:2]));

  // R4: linear order steps the low bits by one
  p_linear_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && !advanceN && !orderSel) |=>
      orderSel || (curAddr[1:0] == ($past(curAddr[1:0]) + 2'd1)));

  // R3: interleaved order changes the low bits exactly as the beat number changes
  p_interleave_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && !advanceN && orderSel) |=>
      !orderSel || ((curAddr[1:0] ^ $past(curAddr[1:0])) == (beatIdx ^ $past(beatIdx))));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;
  localparam int ADDR_W = 18;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              loadStb = 1'b0;
  logic              advanceN = 1'b1;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic              orderSel = 1'b1;
  logic [ADDR_W-1:0] curAddr;
  logic [1:0]        beatIdx;

  int vecCnt = 0;
  int errCnt = 0;
  bit done = 0;

  // reference state
  int refUpper = 0;
  int refStart = 0;
  int refBeat  = 0;
  int refMode  = 1;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .advanceN(advanceN),
    .baseAddr(baseAddr), .orderSel(orderSel), .curAddr(curAddr), .beatIdx(beatIdx)
  );

  function automatic int expLow();
    if (refMode != 0) return refStart ^ refBeat;
    return (refStart + refBeat) % 4;
  endfunction

  task automatic compare(input string tag);
    int expAddr;
    expAddr = refUpper * 4 + expLow();
    vecCnt++;
    if (curAddr !== expAddr[ADDR_W-1:0] || beatIdx !== refBeat[1:0]) begin
      errCnt++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, curAddr, beatIdx, expAddr[ADDR_W-1:0], refBeat);
    end
  endtask

  // called at a falling edge; applies inputs for one rising edge, then compares
  task automatic step(input bit ld, input bit advN, input int addr, input bit mode,
                      input string tag);
    loadStb  = ld;
    advanceN = advN;
    baseAddr = addr[ADDR_W-1:0];
    orderSel = mode;
    @(posedge clk);
    refMode = mode;
    if (ld) begin
      refUpper = (addr & ((1 << ADDR_W) - 1)) / 4;
      refStart = addr % 4;
      refBeat  = 0;
    end else if (!advN) begin
      refBeat = (refBeat + 1) % 4;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    // R1: reset state, asserted and just after release
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // R2, R3: interleaved from start 01 -> 01,00,11,10
    step(1, 1, 'h12345, 1, "R2 load interleaved");
    step(0, 0, 0, 1, "R3 beat1");
    step(0, 0, 0, 1, "R3 beat2");
    step(0, 0, 0, 1, "R3 beat3");
    // R7: wrap back to base
    step(0, 0, 0, 1, "R7 wrap to start");
    // R6: suspend
    step(0, 1, 'h3ffff, 1, "R6 suspend");
    step(0, 1, 0, 1, "R6 suspend again");
    step(0, 0, 0, 1, "R5 resume");

    // R4: linear from start 10 -> 10,11,00,01
    step(1, 1, 'h2a0e, 0, "R2 load linear");
    step(0, 0, 0, 0, "R4 beat1");
    step(0, 0, 0, 0, "R4 beat2");
    step(0, 0, 0, 0, "R4 beat3");
    step(0, 0, 0, 0, "R7 linear wrap");

    // R8: load mid burst with advance also asserted
    step(0, 0, 0, 0, "R5 advance");
    step(1, 0, 'h00003, 1, "R8 load beats advance");
    step(0, 0, 0, 1, "R3 after restart");

    // random traffic; order changes only with a load
    for (int i = 0; i < 400; i++) begin
      bit ld;
      bit advN;
      bit md;
      ld   = ($urandom % 5) == 0;
      advN = $urandom % 2;
      md   = ld ? bit'($urandom % 2) : orderSel;
      step(ld, advN, int'($urandom % (1 << ADDR_W)), md,
           ld ? "R8 random load" : (advN ? "R6 random hold" : "R5 random step"));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule